// File: doc/BRIEF.md
# Rotating-Priority DMA Channel Arbiter

This block decides which of four DMA channels the transfer sequencer serves next. For each channel it takes the external request pin, with its polarity set by a configuration input. It ORs this with the channel's software request flag, then removes the channel if its mask flag is set. A global disable blocks every channel. The highest-priority qualified channel is offered to the sequencer as a one-hot grant on a valid/ready stream. Priority is either fixed or rotating.

Once the sequencer accepts a grant, the channel is busy. Its acknowledge pin is driven active until the sequencer reports the end of the transfer on a single-cycle done strobe. The acknowledge polarity is programmable. Under rotating priority the channel just served becomes the lowest, and the channel after it becomes the highest. The arbiter is then idle again and can offer a new grant.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel is eligible when its mask bit is 0 and either its software request bit is 1 or its request pin is active. A pin is active when high while `cfg_req_low` (control bit 6) is 0, and active when low while it is 1.
- R2: While `cfg_disable` (control bit 2) is 1, no grant is offered, whatever the requests.
- R3: With `cfg_rotate` (control bit 4) at 0, the eligible channel with the lowest number is granted (channel 0 highest, channel 3 lowest).
- R4: With `cfg_rotate` at 1, the transfer of channel c ending makes channel (c+1) mod 4 the highest priority and c the lowest, with the rest in circular order. After reset, channel 0 is highest.
- R5: From idle, an eligible request present at a clock edge raises `gnt_valid` after that edge. `gnt_oh` then holds exactly one bit, and `gnt_oh` and `gnt_valid` stay unchanged until a cycle with `gnt_ready` high, even if the request goes away.
- R6: After the grant is accepted, the acknowledge pin of the granted channel is active from the next cycle until the edge at which `xfer_done` is sampled high; every other acknowledge pin stays inactive. A pin is active high when `cfg_ack_high` (control bit 7) is 1, and active low otherwise.
- R7: The edge that samples `xfer_done` returns the block to idle. All acknowledges go inactive and `gnt_valid` stays low in the following cycle.
- R8: After reset, `gnt_valid` is 0 and all acknowledge pins are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_disable | input | 1 | Control bit 2: block all requests |
| cfg_rotate | input | 1 | Control bit 4: 1 = rotating priority |
| cfg_req_low | input | 1 | Control bit 6: request pins active low |
| cfg_ack_high | input | 1 | Control bit 7: acknowledge pins active high |
| req_pin | input | 4 | External request pins, one per channel |
| sw_req | input | 4 | Software request flags |
| chan_mask | input | 4 | Mask flags, 1 = channel ignored |
| gnt_valid | output | 1 | Grant offered to the sequencer |
| gnt_ready | input | 1 | Sequencer accepts the offered grant |
| gnt_oh | output | 4 | One-hot granted channel, zero when not valid |
| xfer_done | input | 1 | Single-cycle strobe: current transfer finished |
| ack_pin | output | 4 | Per-channel acknowledge outputs |

## Verification
A wrong rotation pointer does not show at once. It appears at the next grant that has two or more channels eligible, as a one-hot that differs from the expected order, so the bench serves sequences with several requests pending. A state register stuck in the offer or busy state shows within a cycle as a stuck `gnt_valid` or acknowledge pin. A grant register that changes while stalled shows on `gnt_oh` during back-pressure. A polarity or qualification fault shows at the first offer as the wrong channel, or as no offer.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OFFER = 2'd1,
    ARB_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_req_qualify.sv
module dma_req_qualify #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req_pin,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic           req_low,
  input  logic           all_off,
  output logic [NCH-1:0] live
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic pin_act;
    assign pin_act = req_low ? ~req_pin[c] : req_pin[c];
    assign live[c] = ~all_off & ~chan_mask[c] & (pin_act | sw_req[c]);
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] live,
  input  logic [IW-1:0]  top_idx,
  output logic           any_live,
  output logic [IW-1:0]  pick_idx
);
  // NCH must be a power of two so that index arithmetic wraps naturally
  always_comb begin
    logic found;
    logic [IW-1:0] idx;
    found    = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      idx = top_idx + IW'(i);
      if (!found && live[idx]) begin
        found    = 1'b1;
        pick_idx = idx;
      end
    end
    any_live = found;
  end
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] live,
  input  logic           any_live,
  input  logic [IW-1:0]  pick_idx,
  input  logic           rotate_en,
  input  logic           gnt_ready,
  input  logic           xfer_done,
  output logic           gnt_valid,
  output logic [NCH-1:0] gnt_oh,
  output logic [NCH-1:0] busy_oh,
  output logic [IW-1:0]  ptr
);
  arb_state_e    state_q;
  logic [IW-1:0] sel_q;
  logic [IW-1:0] ptr_q;
  logic [NCH-1:0] sel_oh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      sel_q   <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (any_live) begin
          sel_q   <= pick_idx;
          state_q <= ARB_OFFER;
        end
        ARB_OFFER: if (gnt_ready) state_q <= ARB_BUSY;
        ARB_BUSY: if (xfer_done) begin
          state_q <= ARB_IDLE;
          if (rotate_en) ptr_q <= sel_q + IW'(1);
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_oh
    assign sel_oh[c] = (sel_q == IW'(c));
  end

  assign gnt_valid = (state_q == ARB_OFFER);
  assign gnt_oh    = gnt_valid ? sel_oh : '0;
  assign busy_oh   = (state_q == ARB_BUSY) ? sel_oh : '0;
  assign ptr       = ptr_q;

  // R5
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_oh)));
  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $onehot(gnt_oh));
  // R1
  gnt_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> ((gnt_oh & ~$past(live)) == '0));
  // R6
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_oh) && !(gnt_valid && (busy_oh != '0)));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_oh != '0) && xfer_done) |=> (busy_oh == '0 && !gnt_valid));
endmodule

// File: rtl/dma_ack_drive.sv
module dma_ack_drive #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] busy_oh,
  input  logic           ack_high,
  output logic [NCH-1:0] ack_pin
);
  for (genvar c = 0; c < NCH; c++) begin : g_ack
    assign ack_pin[c] = ack_high ? busy_oh[c] : ~busy_oh[c];
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_disable,
  input  logic           cfg_rotate,
  input  logic           cfg_req_low,
  input  logic           cfg_ack_high,
  input  logic [NCH-1:0] req_pin,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] chan_mask,
  output logic           gnt_valid,
  input  logic           gnt_ready,
  output logic [NCH-1:0] gnt_oh,
  input  logic           xfer_done,
  output logic [NCH-1:0] ack_pin
);
  logic [NCH-1:0] live;
  logic           any_live;
  logic [IW-1:0]  pick_idx;
  logic [IW-1:0]  ptr;
  logic [IW-1:0]  top_idx;
  logic [NCH-1:0] busy_oh;

  dma_req_qualify #(.NCH(NCH)) u_qual (
    .req_pin  (req_pin),
    .sw_req   (sw_req),
    .chan_mask(chan_mask),
    .req_low  (cfg_req_low),
    .all_off  (cfg_disable),
    .live     (live)
  );

  assign top_idx = cfg_rotate ? ptr : '0;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .live    (live),
    .top_idx (top_idx),
    .any_live(any_live),
    .pick_idx(pick_idx)
  );

  dma_grant_fsm #(.NCH(NCH)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live),
    .any_live (any_live),
    .pick_idx (pick_idx),
    .rotate_en(cfg_rotate),
    .gnt_ready(gnt_ready),
    .xfer_done(xfer_done),
    .gnt_valid(gnt_valid),
    .gnt_oh   (gnt_oh),
    .busy_oh  (busy_oh),
    .ptr      (ptr)
  );

  dma_ack_drive #(.NCH(NCH)) u_ack (
    .busy_oh (busy_oh),
    .ack_high(cfg_ack_high),
    .ack_pin (ack_pin)
  );

  // R2
  disable_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_disable && !gnt_valid) |=> !gnt_valid);
endmodule

// File: tb/dma_chan_arbiter_tb_top.sv
`timescale 1ns/100ps
module dma_chan_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_disable = 1'b0, cfg_rotate = 1'b0, cfg_req_low = 1'b0, cfg_ack_high = 1'b0;
  logic [3:0] req_pin = '0, sw_req = '0, chan_mask = '0;
  logic       gnt_ready = 1'b0, xfer_done = 1'b0;
  logic       gnt_valid;
  logic [3:0] gnt_oh, ack_pin;

  int n_chk = 0;
  int n_fail = 0;
  int    exp_ch_q[$];
  string exp_tag_q[$];

  always #2 clk = ~clk;

  dma_chan_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_disable(cfg_disable), .cfg_rotate(cfg_rotate),
    .cfg_req_low(cfg_req_low), .cfg_ack_high(cfg_ack_high),
    .req_pin(req_pin), .sw_req(sw_req), .chan_mask(chan_mask),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_oh(gnt_oh),
    .xfer_done(xfer_done), .ack_pin(ack_pin)
  );

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] ack_exp(input int ch);
    logic [3:0] oh;
    oh = (ch < 0) ? 4'b0000 : 4'(1 << ch);
    return cfg_ack_high ? oh : ~oh;
  endfunction

  // monitor: compares every accepted grant with the scoreboard
  always @(negedge clk) begin
    if (rst_n && gnt_valid && gnt_ready) begin
      if (exp_ch_q.size() == 0) begin
        check(1'b0, "R3 unexpected grant", gnt_oh, 4'b0000);
      end else begin
        int    e;
        string t;
        e = exp_ch_q.pop_front();
        t = exp_tag_q.pop_front();
        check(gnt_oh == 4'(1 << e), t, gnt_oh, 4'(1 << e));
      end
    end
  end

  // driver: inputs must be set at posedge+1 just before the call
  task automatic do_xfer(input int ch, input string tag, input int stall);
    exp_ch_q.push_back(ch);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    check(!gnt_valid, "R5 no offer before edge", {3'b0, gnt_valid}, 4'b0000);
    @(negedge clk);
    check(gnt_valid && gnt_oh == 4'(1 << ch), "R5 offer after edge", gnt_oh, 4'(1 << ch));
    if (stall > 0) begin
      @(posedge clk); #1;
      req_pin = {4{cfg_req_low}};
      sw_req  = '0;
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        check(gnt_valid && gnt_oh == 4'(1 << ch), "R5 held under stall", gnt_oh, 4'(1 << ch));
      end
    end
    @(posedge clk); #1 gnt_ready = 1'b1;
    @(posedge clk); #1 gnt_ready = 1'b0;
    @(negedge clk);
    check(ack_pin == ack_exp(ch) && !gnt_valid, "R6 ack during transfer", ack_pin, ack_exp(ch));
    @(negedge clk);
    check(ack_pin == ack_exp(ch), "R6 ack held until done", ack_pin, ack_exp(ch));
    @(posedge clk); #1;
    xfer_done = 1'b1;
    req_pin   = {4{cfg_req_low}};
    sw_req    = '0;
    @(posedge clk); #1 xfer_done = 1'b0;
    @(negedge clk);
    check(ack_pin == ack_exp(-1) && !gnt_valid, "R7 idle after done", ack_pin, ack_exp(-1));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!gnt_valid && ack_pin == 4'b1111, "R8 reset state", ack_pin, 4'b1111);
    @(posedge clk); #1 rst_n = 1'b1;

    // R3 fixed priority
    @(posedge clk); #1 req_pin = 4'b1010;
    do_xfer(1, "R3 fixed 1010", 0);
    @(posedge clk); #1 req_pin = 4'b1100;
    do_xfer(2, "R3 fixed 1100", 0);

    // R1 mask, software flag, polarity
    @(posedge clk); #1 req_pin = 4'b0011; chan_mask = 4'b0001;
    do_xfer(1, "R1 masked ch0", 0);
    @(posedge clk); #1 chan_mask = 4'b0000; sw_req = 4'b1000;
    do_xfer(3, "R1 software flag", 0);
    @(posedge clk); #1 cfg_req_low = 1'b1; req_pin = 4'b1011;
    do_xfer(2, "R1 active-low pin", 0);
    @(posedge clk); #1 cfg_req_low = 1'b0; req_pin = 4'b0000;

    // R2 global disable
    @(posedge clk); #1 cfg_disable = 1'b1; req_pin = 4'b1111; sw_req = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!gnt_valid, "R2 disabled no grant", gnt_oh, 4'b0000);
    end
    @(posedge clk); #1 cfg_disable = 1'b0; req_pin = 4'b0000; sw_req = 4'b0000;

    // R6 active-high acknowledge
    @(posedge clk); #1 cfg_ack_high = 1'b1; req_pin = 4'b1000;
    do_xfer(3, "R6 ack high grant", 0);
    @(posedge clk); #1 cfg_ack_high = 1'b0;

    // R4 rotating priority
    @(posedge clk); #1 cfg_rotate = 1'b1; req_pin = 4'b1111;
    do_xfer(0, "R4 rotate first", 0);
    @(posedge clk); #1 req_pin = 4'b1111;
    do_xfer(1, "R4 rotate after 0", 0);
    @(posedge clk); #1 req_pin = 4'b0101;
    do_xfer(2, "R4 rotate after 1", 0);
    @(posedge clk); #1 req_pin = 4'b0101;
    do_xfer(0, "R4 rotate wrap", 0);
    @(posedge clk); #1 req_pin = 4'b1111;
    do_xfer(1, "R4 rotate after wrap", 0);

    // R3 back to fixed
    @(posedge clk); #1 cfg_rotate = 1'b0; req_pin = 4'b1111;
    do_xfer(0, "R3 fixed after rotate", 0);

    // R5 back-pressure with request withdrawn
    @(posedge clk); #1 req_pin = 4'b0100;
    do_xfer(2, "R5 stalled grant", 3);

    repeat (2) @(negedge clk);
    check(exp_ch_q.size() == 0, "R5 all grants accepted", 4'(exp_ch_q.size()), 4'b0000);
    summary();
    $finish;
  end
endmodule